// File: doc/BRIEF.md
# Set-Associative Cache Controller

This block is a byte-addressed cache that sits between a processor-side request port and a block-oriented memory port. Its geometry is set by parameters: the number of sets (a power of two), the number of ways in each set, and the block size in bytes (a power of two). A single design therefore covers everything from a direct-mapped cache (one way) to multi-way set-associative operation. The processor presents one request at a time: a read or a one-byte write at an address. The block answers with a completion pulse, a hit flag and, for reads, the addressed byte.

On a miss the controller fetches the whole block from memory. Within a set, the line to replace is chosen by least-recently-used order, and an empty line is always used before a valid one is evicted. A parameter selects the write policy pair. Write-back with write-allocate keeps modified lines dirty in the cache and writes them to memory only on eviction. Write-through with no-write-allocate sends every write to memory as a single byte and never fills a line because of a write.

Top module: `sa_cache`

## Requirements
- R1: An address splits into a tag (upper bits), a set index (middle SET_BITS bits) and a byte offset (lowest OFF_BITS bits). A read returns the byte at that offset within the block. A memory block occupies bits [8k+7:8k] for byte k.
- R2: After reset every line is invalid and the replacement order is reset. `cpu_ready` is 1 and `mem_req` is 0, so the first access to any address is a miss.
- R3: A hit needs a valid line in the selected set whose tag equals the request tag. A hit finishes with `cpu_done` asserted for one cycle, on the second clock edge after the edge that accepted the request, and it causes no memory transaction.
- R4: With a 4-bit address, 2-byte blocks, 4 sets and 1 way, the reads 0, 1, 7, 8, 0 from an empty cache give miss, hit, miss, miss, miss.
- R5: With a 4-bit address, 2-byte blocks, 2 sets and 2 ways, the same reads from an empty cache give miss, hit, miss, miss, hit.
- R6: On a miss the controller fills an invalid way first if the set has one. Otherwise it replaces the least recently used way. Every hit and every refill makes the accessed way the most recently used.
- R7: In write-back mode, a write hit changes only the cached byte and marks the line dirty. No memory transaction takes place.
- R8: In write-back mode, evicting a dirty line first writes its whole block (`mem_we`=1, `mem_byte`=0) to the block-aligned address of the victim, and only then issues the refill read. Evicting a clean line issues no write.
- R9: In write-back mode, a write miss refills the block, then writes the byte into the cache, and reports a miss. A later read of that byte hits and returns the new value.
- R10: In write-through mode, a write hit updates the cached byte and also sends a one-byte write (`mem_byte`=1, data in `mem_wdata[7:0]`) to the full address. A write miss sends the same one-byte write and leaves the cache contents unchanged.
- R11: Requests are served one at a time. `cpu_ready` is 0 from the accepting edge until completion. `mem_req` with its address and type stays stable until `mem_ack`, and it drops on the edge after `mem_ack`.
- R12: After every dirty line has been evicted, memory holds exactly the bytes that a plain byte array would hold after the same sequence of writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_valid | input | 1 | Request present |
| cpu_ready | output | 1 | Controller idle; request accepted when both high |
| cpu_write | input | 1 | 1 = byte write, 0 = read |
| cpu_addr | input | ADDR_W | Byte address |
| cpu_wdata | input | 8 | Write byte |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_hit | output | 1 | Hit flag, valid with cpu_done |
| cpu_rdata | output | 8 | Read byte, valid with cpu_done for reads |
| mem_req | output | 1 | Memory transaction request |
| mem_we | output | 1 | 1 = write, 0 = block read |
| mem_byte | output | 1 | 1 = single-byte write in mem_wdata[7:0] |
| mem_addr | output | ADDR_W | Block-aligned address, or the full address for byte writes |
| mem_wdata | output | 8*2^OFF_BITS | Write data |
| mem_ack | input | 1 | One-cycle completion of the memory transaction |
| mem_rdata | input | 8*2^OFF_BITS | Block data, valid with mem_ack |

## Verification
The assertions check the handshake rules on every cycle. These are: the port goes busy once a request is accepted, it stays busy while memory traffic is pending, a memory request holds steady until it is acknowledged, completion lasts a single cycle, and the memory write width matches the chosen policy. Hit and miss sequences, the replacement order, dirty write-back ordering, write-allocate versus bypass, and final memory consistency depend on the history of whole access sequences. Only the bench's directed scenarios can show those, by comparing against a reference byte array and hand-derived hit patterns on a 2-way write-back instance and a direct-mapped write-through instance.

// File: rtl/sa_cache_pkg.sv
// Shared types for the set-associative cache controller.
package sa_cache_pkg;

    // Controller sequencing states
    typedef enum logic [2:0] {
        ST_IDLE,    // waiting for a processor request
        ST_LOOKUP,  // tag compare on the latched request
        ST_WBACK,   // dirty victim block being written to memory
        ST_FILL,    // block refill read outstanding
        ST_WTHRU    // single-byte memory write outstanding
    } cache_state_t;

endpackage

// File: rtl/sa_cache_lru.sv
// Per-set recency tracking. Each way holds an age (0 = most recent).
// Assumes the ages in each set always form a permutation of 0..WAYS-1.
// With one way, no storage is built and the age is always zero.
module sa_cache_lru #(
    parameter int SETS     = 4,
    parameter int SET_BITS = 2,
    parameter int WAYS     = 2,
    parameter int AGE_W    = 1,
    parameter int WAY_W    = 1
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            touch_en,
    input  logic [SET_BITS-1:0]             touch_set,
    input  logic [WAY_W-1:0]                touch_way,
    input  logic [SET_BITS-1:0]             read_set,
    output logic [WAYS-1:0][AGE_W-1:0]      read_age
);

    if (WAYS > 1) begin : g_multi
        logic [SETS-1:0][WAYS-1:0][AGE_W-1:0] age_q;

        // Reset to a fixed order; promote touched way, age younger ones
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                for (int s = 0; s < SETS; s++)
                    for (int w = 0; w < WAYS; w++)
                        age_q[s][w] <= AGE_W'(w);
            end else if (touch_en) begin
                for (int w = 0; w < WAYS; w++) begin
                    if (WAY_W'(w) == touch_way)
                        age_q[touch_set][w] <= '0;
                    else if (age_q[touch_set][w] < age_q[touch_set][touch_way])
                        age_q[touch_set][w] <= age_q[touch_set][w] + 1'b1;
                end
            end
        end

        assign read_age = age_q[read_set];
    end else begin : g_single
        logic unused_inputs;
        assign unused_inputs = &{1'b0, clk, rst_n, touch_en, touch_set, touch_way, read_set};
        assign read_age = '0;
    end

endmodule

// File: rtl/sa_cache_lookup.sv
// Combinational probe of one set: parallel tag compare and victim choice.
// The victim is the lowest invalid way, or else the way with the oldest age.
module sa_cache_lookup #(
    parameter int WAYS  = 2,
    parameter int TAG_W = 6,
    parameter int AGE_W = 1,
    parameter int WAY_W = 1
) (
    input  logic [WAYS-1:0]              line_valid,
    input  logic [WAYS-1:0][TAG_W-1:0]   line_tag,
    input  logic [WAYS-1:0][AGE_W-1:0]   line_age,
    input  logic [TAG_W-1:0]             probe_tag,
    output logic                         hit,
    output logic [WAY_W-1:0]             hit_way,
    output logic [WAY_W-1:0]             victim_way
);

    logic victim_found;

    // Tag match across all ways of the set
    always_comb begin
        hit     = 1'b0;
        hit_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (!hit && line_valid[w] && line_tag[w] == probe_tag) begin
                hit     = 1'b1;
                hit_way = WAY_W'(w);
            end
        end
    end

    // Replacement choice: empty way first, then the least recent one
    always_comb begin
        victim_found = 1'b0;
        victim_way   = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (!victim_found && !line_valid[w]) begin
                victim_found = 1'b1;
                victim_way   = WAY_W'(w);
            end
        end
        for (int w = 0; w < WAYS; w++) begin
            if (!victim_found && line_age[w] == AGE_W'(WAYS - 1)) begin
                victim_found = 1'b1;
                victim_way   = WAY_W'(w);
            end
        end
    end

endmodule

// File: rtl/sa_cache.sv
// Set-associative byte cache with block refill and selectable write policy.
// Assumes SET_BITS >= 1, OFF_BITS >= 1 and a tag of at least one bit.
// One request is handled at a time; memory acknowledges with a one-cycle pulse.
module sa_cache
    import sa_cache_pkg::*;
#(
    parameter int ADDR_W     = 10,
    parameter int SET_BITS   = 2,
    parameter int WAY_COUNT  = 2,
    parameter int OFF_BITS   = 2,
    parameter bit WRITE_BACK = 1'b1
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              cpu_valid,
    output logic                              cpu_ready,
    input  logic                              cpu_write,
    input  logic [ADDR_W-1:0]                 cpu_addr,
    input  logic [7:0]                        cpu_wdata,
    output logic                              cpu_done,
    output logic                              cpu_hit,
    output logic [7:0]                        cpu_rdata,
    output logic                              mem_req,
    output logic                              mem_we,
    output logic                              mem_byte,
    output logic [ADDR_W-1:0]                 mem_addr,
    output logic [8*(2**OFF_BITS)-1:0]        mem_wdata,
    input  logic                              mem_ack,
    input  logic [8*(2**OFF_BITS)-1:0]        mem_rdata
);

    localparam int SETS   = 2 ** SET_BITS;
    localparam int LINE_W = 8 * (2 ** OFF_BITS);
    localparam int TAG_W  = ADDR_W - SET_BITS - OFF_BITS;
    localparam int AGE_W  = (WAY_COUNT > 1) ? $clog2(WAY_COUNT) : 1;
    localparam int WAY_W  = AGE_W;

    cache_state_t state_q;

    // Latched request
    logic              req_write_q;
    logic [ADDR_W-1:0] req_addr_q;
    logic [7:0]        req_wdata_q;
    logic              miss_q;
    logic [WAY_W-1:0]  victim_q;

    wire [TAG_W-1:0]    req_tag = req_addr_q[ADDR_W-1 -: TAG_W];
    wire [SET_BITS-1:0] req_set = req_addr_q[OFF_BITS +: SET_BITS];
    wire [OFF_BITS-1:0] req_off = req_addr_q[OFF_BITS-1:0];

    // Line storage
    logic [SETS-1:0][WAY_COUNT-1:0]             valid_q;
    logic [SETS-1:0][WAY_COUNT-1:0]             dirty_q;
    logic [SETS-1:0][WAY_COUNT-1:0][TAG_W-1:0]  tag_q;
    logic [SETS-1:0][WAY_COUNT-1:0][LINE_W-1:0] data_q;

    logic [WAY_COUNT-1:0][AGE_W-1:0] set_age;
    logic                            hit;
    logic [WAY_W-1:0]                hit_way;
    logic [WAY_W-1:0]                victim_way;
    logic                            touch;
    logic [LINE_W-1:0]               hit_line;

    assign cpu_ready = (state_q == ST_IDLE);
    assign touch     = (state_q == ST_LOOKUP) && hit;
    assign hit_line  = data_q[req_set][hit_way];

    sa_cache_lru #(
        .SETS(SETS), .SET_BITS(SET_BITS), .WAYS(WAY_COUNT),
        .AGE_W(AGE_W), .WAY_W(WAY_W)
    ) u_lru (
        .clk(clk), .rst_n(rst_n),
        .touch_en(touch), .touch_set(req_set), .touch_way(hit_way),
        .read_set(req_set), .read_age(set_age)
    );

    sa_cache_lookup #(
        .WAYS(WAY_COUNT), .TAG_W(TAG_W), .AGE_W(AGE_W), .WAY_W(WAY_W)
    ) u_lookup (
        .line_valid(valid_q[req_set]), .line_tag(tag_q[req_set]),
        .line_age(set_age), .probe_tag(req_tag),
        .hit(hit), .hit_way(hit_way), .victim_way(victim_way)
    );

    // Request sequencing, line updates and memory transactions
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            valid_q     <= '0;
            dirty_q     <= '0;
            req_write_q <= 1'b0;
            req_addr_q  <= '0;
            req_wdata_q <= '0;
            miss_q      <= 1'b0;
            victim_q    <= '0;
            cpu_done    <= 1'b0;
            cpu_hit     <= 1'b0;
            cpu_rdata   <= '0;
            mem_req     <= 1'b0;
            mem_we      <= 1'b0;
            mem_byte    <= 1'b0;
            mem_addr    <= '0;
            mem_wdata   <= '0;
        end else begin
            cpu_done <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (cpu_valid) begin
                        req_write_q <= cpu_write;
                        req_addr_q  <= cpu_addr;
                        req_wdata_q <= cpu_wdata;
                        miss_q      <= 1'b0;
                        state_q     <= ST_LOOKUP;
                    end
                end
                ST_LOOKUP: begin
                    if (hit) begin
                        if (req_write_q) begin
                            data_q[req_set][hit_way][{req_off, 3'b000} +: 8] <= req_wdata_q;
                            if (WRITE_BACK) dirty_q[req_set][hit_way] <= 1'b1;
                        end
                        if (req_write_q && !WRITE_BACK) begin
                            mem_req   <= 1'b1;
                            mem_we    <= 1'b1;
                            mem_byte  <= 1'b1;
                            mem_addr  <= req_addr_q;
                            mem_wdata <= LINE_W'(req_wdata_q);
                            state_q   <= ST_WTHRU;
                        end else begin
                            cpu_done  <= 1'b1;
                            cpu_hit   <= !miss_q;
                            cpu_rdata <= hit_line[{req_off, 3'b000} +: 8];
                            state_q   <= ST_IDLE;
                        end
                    end else begin
                        miss_q <= 1'b1;
                        if (req_write_q && !WRITE_BACK) begin
                            mem_req   <= 1'b1;
                            mem_we    <= 1'b1;
                            mem_byte  <= 1'b1;
                            mem_addr  <= req_addr_q;
                            mem_wdata <= LINE_W'(req_wdata_q);
                            state_q   <= ST_WTHRU;
                        end else if (valid_q[req_set][victim_way] && dirty_q[req_set][victim_way]) begin
                            victim_q  <= victim_way;
                            mem_req   <= 1'b1;
                            mem_we    <= 1'b1;
                            mem_byte  <= 1'b0;
                            mem_addr  <= {tag_q[req_set][victim_way], req_set, {OFF_BITS{1'b0}}};
                            mem_wdata <= data_q[req_set][victim_way];
                            state_q   <= ST_WBACK;
                        end else begin
                            victim_q  <= victim_way;
                            mem_req   <= 1'b1;
                            mem_we    <= 1'b0;
                            mem_byte  <= 1'b0;
                            mem_addr  <= {req_tag, req_set, {OFF_BITS{1'b0}}};
                            state_q   <= ST_FILL;
                        end
                    end
                end
                ST_WBACK: begin
                    // Victim now clean in memory: free it and probe again
                    if (mem_ack) begin
                        mem_req                    <= 1'b0;
                        dirty_q[req_set][victim_q] <= 1'b0;
                        valid_q[req_set][victim_q] <= 1'b0;
                        state_q                    <= ST_LOOKUP;
                    end
                end
                ST_FILL: begin
                    // Install the block; the repeated probe then hits
                    if (mem_ack) begin
                        mem_req                    <= 1'b0;
                        valid_q[req_set][victim_q] <= 1'b1;
                        dirty_q[req_set][victim_q] <= 1'b0;
                        tag_q[req_set][victim_q]   <= req_tag;
                        data_q[req_set][victim_q]  <= mem_rdata;
                        state_q                    <= ST_LOOKUP;
                    end
                end
                ST_WTHRU: begin
                    if (mem_ack) begin
                        mem_req  <= 1'b0;
                        cpu_done <= 1'b1;
                        cpu_hit  <= !miss_q;
                        state_q  <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/sa_cache_chk.sv
// Protocol checker for sa_cache, attached through bind. Observes ports only.
module sa_cache_chk #(
    parameter int ADDR_W     = 10,
    parameter bit WRITE_BACK = 1'b1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_valid,
    input logic              cpu_ready,
    input logic              cpu_done,
    input logic              mem_req,
    input logic              mem_we,
    input logic              mem_byte,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_ack
);

    // R2: idle with no memory request right after reset
    a_r2_idle_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> cpu_ready && !mem_req);

    // R11: accepted request makes the port busy
    a_r11_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_valid && cpu_ready |=> !cpu_ready);

    // R11: busy whenever memory traffic is pending
    a_r11_busy_during_mem: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !cpu_ready);

    // R11: request held steady until acknowledged
    a_r11_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_byte));

    // R11: request withdrawn after acknowledge
    a_r11_req_drops: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_ack |=> !mem_req);

    // R3: completion is a single-cycle pulse
    a_r3_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_done |=> !cpu_done);

    if (WRITE_BACK) begin : g_wb
        // R8: write-back mode moves only whole blocks
        a_r8_block_writes: assert property (@(posedge clk) disable iff (!rst_n)
            mem_req |-> !mem_byte);
    end else begin : g_wt
        // R10: write-through mode writes single bytes only
        a_r10_byte_writes: assert property (@(posedge clk) disable iff (!rst_n)
            mem_req && mem_we |-> mem_byte);
    end

endmodule

bind sa_cache sa_cache_chk #(.ADDR_W(ADDR_W), .WRITE_BACK(WRITE_BACK)) u_sa_cache_chk (
    .clk(clk), .rst_n(rst_n), .cpu_valid(cpu_valid), .cpu_ready(cpu_ready),
    .cpu_done(cpu_done), .mem_req(mem_req), .mem_we(mem_we), .mem_byte(mem_byte),
    .mem_addr(mem_addr), .mem_ack(mem_ack)
);

// File: tb/sa_cache_bench.sv
// Directed bench: instance 0 is 2 sets x 2 ways write-back,
// instance 1 is 4 sets x 1 way write-through; both 4-bit address, 2-byte blocks.
module sa_cache_bench;

    logic clk = 1'b0;
    logic rst_n;
    always #5 clk = ~clk;

    logic       cv [2];
    logic       cw [2];
    logic [3:0] ca [2];
    logic [7:0] cd [2];
    logic       crdy [2];
    logic       cdone [2];
    logic       chit [2];
    logic [7:0] crd [2];
    logic       mreq [2];
    logic       mwe [2];
    logic       mbyte [2];
    logic [3:0] maddr [2];
    logic [15:0] mwd [2];
    logic       mack [2];
    logic [15:0] mrd [2];

    logic [7:0] mem [2][16];
    logic [7:0] ref_mem [2][16];
    int n_rd [2];
    int n_wblk [2];
    int n_wbyte [2];
    int seqlog [2];
    int last_wblk_addr [2];
    int wcnt [2];

    int checks = 0;
    int failures = 0;

    sa_cache #(.ADDR_W(4), .SET_BITS(1), .WAY_COUNT(2), .OFF_BITS(1), .WRITE_BACK(1'b1)) u_sa_cache (
        .clk(clk), .rst_n(rst_n), .cpu_valid(cv[0]), .cpu_ready(crdy[0]), .cpu_write(cw[0]),
        .cpu_addr(ca[0]), .cpu_wdata(cd[0]), .cpu_done(cdone[0]), .cpu_hit(chit[0]),
        .cpu_rdata(crd[0]), .mem_req(mreq[0]), .mem_we(mwe[0]), .mem_byte(mbyte[0]),
        .mem_addr(maddr[0]), .mem_wdata(mwd[0]), .mem_ack(mack[0]), .mem_rdata(mrd[0]));

    sa_cache #(.ADDR_W(4), .SET_BITS(2), .WAY_COUNT(1), .OFF_BITS(1), .WRITE_BACK(1'b0)) u_sa_cache_dm (
        .clk(clk), .rst_n(rst_n), .cpu_valid(cv[1]), .cpu_ready(crdy[1]), .cpu_write(cw[1]),
        .cpu_addr(ca[1]), .cpu_wdata(cd[1]), .cpu_done(cdone[1]), .cpu_hit(chit[1]),
        .cpu_rdata(crd[1]), .mem_req(mreq[1]), .mem_we(mwe[1]), .mem_byte(mbyte[1]),
        .mem_addr(maddr[1]), .mem_wdata(mwd[1]), .mem_ack(mack[1]), .mem_rdata(mrd[1]));

    function automatic logic [7:0] seed(input int g, input int a);
        return 8'((a * 29 + 11 + g * 7) & 255);
    endfunction

    // Behavioural memory: three-cycle latency, one-cycle acknowledge
    initial begin
        for (int g = 0; g < 2; g++) begin
            for (int a = 0; a < 16; a++) mem[g][a] = seed(g, a);
            mack[g] = 1'b0; mrd[g] = '0; n_rd[g] = 0; n_wblk[g] = 0;
            n_wbyte[g] = 0; seqlog[g] = 0; last_wblk_addr[g] = -1; wcnt[g] = 0;
        end
        forever begin
            @(negedge clk);
            for (int g = 0; g < 2; g++) begin
                if (mack[g]) mack[g] = 1'b0;
                else if (mreq[g] === 1'b1) begin
                    if (wcnt[g] < 2) wcnt[g]++;
                    else begin
                        wcnt[g] = 0;
                        mack[g] = 1'b1;
                        if (mwe[g] && mbyte[g]) begin
                            mem[g][maddr[g]] = mwd[g][7:0];
                            n_wbyte[g]++; seqlog[g] = (seqlog[g] << 2) | 3;
                        end else if (mwe[g]) begin
                            mem[g][{maddr[g][3:1], 1'b0}] = mwd[g][7:0];
                            mem[g][{maddr[g][3:1], 1'b1}] = mwd[g][15:8];
                            n_wblk[g]++; last_wblk_addr[g] = int'(maddr[g]);
                            seqlog[g] = (seqlog[g] << 2) | 2;
                        end else begin
                            mrd[g] = {mem[g][{maddr[g][3:1], 1'b1}], mem[g][{maddr[g][3:1], 1'b0}]};
                            n_rd[g]++; seqlog[g] = (seqlog[g] << 2) | 1;
                        end
                    end
                end
            end
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One processor access; returns hit flag, read byte and cycles to completion
    task automatic access(input int d, input bit wr, input logic [3:0] addr, input logic [7:0] wdata,
                          output bit hit, output logic [7:0] rdata, output int cycles);
        bit busy_ok = 1'b1;
        @(negedge clk);
        cv[d] = 1'b1; cw[d] = wr; ca[d] = addr; cd[d] = wdata;
        @(posedge clk);
        #1 cv[d] = 1'b0;
        cycles = 0;
        do begin
            @(negedge clk);
            cycles++;
            if (!cdone[d] && crdy[d]) busy_ok = 1'b0;
        end while (!cdone[d] && cycles < 200);
        hit = chit[d];
        rdata = crd[d];
        check(busy_ok && cdone[d], "R11 busy until done", int'(busy_ok), 1);
        if (wr) ref_mem[d][addr] = wdata;
    endtask

    // Access with expected hit flag; reads compared against the reference array
    task automatic expect_access(input int d, input bit wr, input logic [3:0] addr,
                                 input logic [7:0] wdata, input bit exp_hit, input string req);
        bit hit; logic [7:0] rdata; int cycles;
        access(d, wr, addr, wdata, hit, rdata, cycles);
        check(hit == exp_hit, {req, " hit flag"}, int'(hit), int'(exp_hit));
        if (!wr) check(rdata == ref_mem[d][addr], {req, " R1 read byte"}, int'(rdata), int'(ref_mem[d][addr]));
    endtask

    task automatic test_reset();
        for (int g = 0; g < 2; g++) begin
            check(crdy[g] == 1'b1, "R2 ready after reset", int'(crdy[g]), 1);
            check(mreq[g] == 1'b0, "R2 no memory request after reset", int'(mreq[g]), 0);
        end
    endtask

    task automatic test_dm_trace();
        int rd0;
        bit hit; logic [7:0] rdata; int cycles;
        expect_access(1, 0, 4'd0, 8'd0, 1'b0, "R4 t0");
        rd0 = n_rd[1];
        access(1, 0, 4'd1, 8'd0, hit, rdata, cycles);
        check(hit == 1'b1, "R4 t1 hit", int'(hit), 1);
        check(rdata == ref_mem[1][1], "R1 offset byte", int'(rdata), int'(ref_mem[1][1]));
        check(cycles == 2, "R3 hit latency", cycles, 2);
        check(n_rd[1] == rd0, "R3 hit without memory traffic", n_rd[1] - rd0, 0);
        expect_access(1, 0, 4'd7, 8'd0, 1'b0, "R4 t2");
        expect_access(1, 0, 4'd8, 8'd0, 1'b0, "R4 t3");
        expect_access(1, 0, 4'd0, 8'd0, 1'b0, "R4 t4");
    endtask

    task automatic test_sa_trace();
        expect_access(0, 0, 4'd0, 8'd0, 1'b0, "R5 t0");
        expect_access(0, 0, 4'd1, 8'd0, 1'b1, "R5 t1");
        expect_access(0, 0, 4'd7, 8'd0, 1'b0, "R5 t2");
        expect_access(0, 0, 4'd8, 8'd0, 1'b0, "R5 t3");
        expect_access(0, 0, 4'd0, 8'd0, 1'b1, "R5 t4");
    endtask

    task automatic test_lru();
        int wb0 = n_wblk[0];
        expect_access(0, 0, 4'd12, 8'd0, 1'b0, "R6 evict older line");
        expect_access(0, 0, 4'd0, 8'd0, 1'b1, "R6 recent line kept");
        expect_access(0, 0, 4'd8, 8'd0, 1'b0, "R6 evicted line misses");
        expect_access(0, 0, 4'd12, 8'd0, 1'b0, "R6 refresh order");
        expect_access(0, 0, 4'd0, 8'd0, 1'b0, "R6 refresh order 2");
        check(n_wblk[0] == wb0, "R8 clean eviction writes nothing", n_wblk[0] - wb0, 0);
    endtask

    task automatic test_wb_hit();
        int wb0 = n_wblk[0], rd0 = n_rd[0], by0 = n_wbyte[0];
        expect_access(0, 1, 4'd1, 8'hA5, 1'b1, "R7 write hit");
        check((n_wblk[0] + n_rd[0] + n_wbyte[0]) == (wb0 + rd0 + by0), "R7 no memory traffic",
              n_wblk[0] + n_rd[0] + n_wbyte[0] - wb0 - rd0 - by0, 0);
        check(mem[0][1] == seed(0, 1), "R7 memory untouched", int'(mem[0][1]), int'(seed(0, 1)));
        expect_access(0, 0, 4'd1, 8'd0, 1'b1, "R7 read back");
    endtask

    task automatic test_dirty_evict();
        int wb0, rd0;
        expect_access(0, 0, 4'd8, 8'd0, 1'b0, "R8 evict clean line");
        wb0 = n_wblk[0]; rd0 = n_rd[0];
        expect_access(0, 0, 4'd12, 8'd0, 1'b0, "R8 evict dirty line");
        check(n_wblk[0] - wb0 == 1, "R8 one block written", n_wblk[0] - wb0, 1);
        check(n_rd[0] - rd0 == 1, "R8 one refill", n_rd[0] - rd0, 1);
        check((seqlog[0] & 15) == 9, "R8 write before refill", seqlog[0] & 15, 9);
        check(last_wblk_addr[0] == 0, "R8 victim block address", last_wblk_addr[0], 0);
        check(mem[0][1] == 8'hA5, "R8 dirty byte reached memory", int'(mem[0][1]), 'hA5);
    endtask

    task automatic test_write_alloc();
        int rd0 = n_rd[0], wb0 = n_wblk[0];
        expect_access(0, 1, 4'd5, 8'h5A, 1'b0, "R9 write miss");
        check(n_rd[0] - rd0 == 1 && n_wblk[0] == wb0, "R9 refill only", n_rd[0] - rd0, 1);
        expect_access(0, 0, 4'd5, 8'd0, 1'b1, "R9 read new byte");
        expect_access(0, 0, 4'd4, 8'd0, 1'b1, "R9 neighbour byte");
    endtask

    task automatic test_write_through();
        int by0 = n_wbyte[1], rd0 = n_rd[1];
        expect_access(1, 1, 4'd7, 8'hC3, 1'b1, "R10 write hit");
        check(n_wbyte[1] - by0 == 1, "R10 hit sends byte write", n_wbyte[1] - by0, 1);
        check(mem[1][7] == 8'hC3, "R10 memory updated", int'(mem[1][7]), 'hC3);
        expect_access(1, 0, 4'd7, 8'd0, 1'b1, "R10 cached copy updated");
        expect_access(1, 1, 4'd15, 8'h3C, 1'b0, "R10 write miss");
        check(n_wbyte[1] - by0 == 2 && n_rd[1] == rd0, "R10 no allocation on miss", n_rd[1] - rd0, 0);
        check(mem[1][15] == 8'h3C, "R10 miss byte in memory", int'(mem[1][15]), 'h3C);
        expect_access(1, 0, 4'd7, 8'd0, 1'b1, "R10 resident line kept");
        expect_access(1, 0, 4'd15, 8'd0, 1'b0, "R10 written block not cached");
    endtask

    task automatic test_flush();
        int bad;
        expect_access(0, 0, 4'd0, 8'd0, 1'b0, "R12 flush a");
        expect_access(0, 0, 4'd8, 8'd0, 1'b0, "R12 flush b");
        for (int g = 0; g < 2; g++) begin
            bad = 0;
            for (int a = 0; a < 16; a++) if (mem[g][a] != ref_mem[g][a]) bad++;
            check(bad == 0, "R12 memory matches reference", bad, 0);
        end
    endtask

    initial begin
        for (int g = 0; g < 2; g++) begin
            cv[g] = 1'b0; cw[g] = 1'b0; ca[g] = '0; cd[g] = '0;
            for (int a = 0; a < 16; a++) ref_mem[g][a] = seed(g, a);
        end
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        test_dm_trace();
        test_sa_trace();
        test_lru();
        test_wb_hit();
        test_dirty_evict();
        test_write_alloc();
        test_write_through();
        test_flush();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #1000000;
        checks++;
        failures++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule